// File: doc/BRIEF.md
# Quantized SIMD Multiply-Accumulate ALU

This unit is the arithmetic core of one processing element in a linear accelerator array. On each cycle it can accept one operation. The operation has two 32-bit operand words, a 48-bit accumulator word and a 2-bit opcode, all qualified by one input valid strobe. The accumulator holds two independent 24-bit partial-sum lanes. Each opcode adds a per-lane quantity into those lanes.

There are three operations:
- A two-lane signed 8-bit by 8-bit multiply-add.
- A two-lane 24-bit add for merging partial sums.
- A fused dequantising multiply-accumulate. In this operation each weight byte carries an unsigned 5-bit scale and a signed 3-bit weight, and the scale times weight is multiplied by a signed 8-bit activation in the same operation.

The work is split over two register stages. The products and addends are formed in the first stage and the lane sums in the second. A result therefore leaves exactly two cycles after its operands arrive, and a new operation may enter every cycle.

Top module: `qsimd_mac_alu`

## Requirements
- R1: While reset (active-low `rst_n`) is asserted, and after it is released with no operation issued, `out_valid` is 0 and `result` is 0.
- R2: An operation accepted in cycle n (`in_valid`=1 with a non-reserved opcode) raises `out_valid` in cycle n+2 with its result. Back-to-back operations each produce their own result in consecutive cycles.
- R3: Opcode 2'b00 (byte multiply-add) works on two lanes. Lane 0 is `result[23:0]` = `acc_in[23:0]` + signed(`op_a[7:0]`) × signed(`op_b[7:0]`). Lane 1 is `result[47:24]` = `acc_in[47:24]` + signed(`op_a[15:8]`) × signed(`op_b[15:8]`).
- R4: Opcode 2'b01 (lane add) gives lane 0 = `acc_in[23:0]` + `op_a[23:0]` and lane 1 = `acc_in[47:24]` + `op_b[23:0]`.
- R5: Opcode 2'b10 (scale-weight MAC) treats byte i of `op_a` (bits [8i+7:8i]) as an unsigned scale in its bits [7:3] and a signed weight in its bits [2:0]. Lane i = acc lane i + scale × weight × signed(byte i of `op_b`).
- R6: Every lane sum wraps modulo 2^24, and no carry or borrow passes from lane 0 into lane 1.
- R7: Opcode 2'b11 is reserved. It never produces an output strobe and leaves `result` unchanged.
- R8: In any cycle where `out_valid` is 0, `result` keeps its previous value. Inputs presented with `in_valid`=0 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operation strobe |
| opcode | input | 2 | 00 byte MAC, 01 lane add, 10 scale-weight MAC, 11 reserved |
| op_a | input | 32 | Operand A (activation-side bytes, or packed scale/weight, or lane-0 addend) |
| op_b | input | 32 | Operand B (second-factor bytes, or lane-1 addend) |
| acc_in | input | 48 | Two 24-bit accumulator lanes |
| out_valid | output | 1 | Result strobe, two cycles after the accepted operation |
| result | output | 48 | Two 24-bit result lanes |

## Verification
Two things happen in the same cycle in a full pipeline: one operation forms its products in the first stage while the previous operation's lane sums are registered in the second. The bench streams operations with no gaps and changes opcode, operands and accumulator on every cycle. Reserved and idle slots are mixed in, so any mix-up between the stages would attach a wrong product to a wrong accumulator, or shift a strobe. Every cycle the bench compares both `out_valid` and `result` against a model that is delayed two slots and holds its last value.

// File: rtl/qsimd_mac_alu.sv
module qsimd_mac_alu (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [1:0]  opcode,
  input  logic [31:0] op_a,
  input  logic [31:0] op_b,
  input  logic [47:0] acc_in,
  output logic        out_valid,
  output logic [47:0] result
);
  localparam logic [1:0] OP_BMAC = 2'b00;
  localparam logic [1:0] OP_LADD = 2'b01;
  localparam logic [1:0] OP_SWMAC = 2'b10;
  localparam logic [1:0] OP_RSVD = 2'b11;

  logic [23:0] addend [2];
  logic [23:0] s1_add [2];
  logic [47:0] s1_acc;
  logic        s1_v;
  logic [1:0]  s1_op;

  for (genvar i = 0; i < 2; i++) begin : g_lane
    logic signed [7:0]  xa, xb;
    logic signed [5:0]  scale;
    logic signed [2:0]  wt;
    logic signed [15:0] pbyte;
    logic signed [8:0]  sw;
    logic signed [16:0] pq;
    assign xa    = op_a[8*i +: 8];
    assign xb    = op_b[8*i +: 8];
    assign scale = {1'b0, op_a[8*i+3 +: 5]};
    assign wt    = op_a[8*i +: 3];
    assign pbyte = 16'(xa) * 16'(xb);
    assign sw    = 9'(scale) * 9'(wt);
    assign pq    = 17'(sw) * 17'(xb);
    always_comb begin
      case (opcode)
        OP_BMAC:  addend[i] = {{8{pbyte[15]}}, pbyte};
        OP_SWMAC: addend[i] = {{7{pq[16]}}, pq};
        default:  addend[i] = (i == 0) ? op_a[23:0] : op_b[23:0];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v      <= 1'b0;
      s1_op     <= OP_BMAC;
      s1_acc    <= '0;
      s1_add[0] <= '0;
      s1_add[1] <= '0;
    end else begin
      s1_v <= in_valid && (opcode != OP_RSVD);
      if (in_valid && (opcode != OP_RSVD)) begin
        s1_op     <= opcode;
        s1_acc    <= acc_in;
        s1_add[0] <= addend[0];
        s1_add[1] <= addend[1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= s1_v;
      if (s1_v) result <= {s1_acc[47:24] + s1_add[1], s1_acc[23:0] + s1_add[0]};
    end
  end

  p_strobe_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(s1_v));
  p_reserved_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode == OP_RSVD) |=> !s1_v);
  p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(result));
  p_bmac_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_v && s1_op == OP_BMAC) |->
      ($signed(s1_add[0]) >= -24'sd16256 && $signed(s1_add[0]) <= 24'sd16384));
  p_swmac_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_v && s1_op == OP_SWMAC) |->
      ($signed(s1_add[1]) >= -24'sd15872 && $signed(s1_add[1]) <= 24'sd15872));
endmodule

// File: tb/tb_qsimd_mac_alu.sv
module tb_qsimd_mac_alu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  opcode = 2'b00;
  logic [31:0] op_a = '0;
  logic [31:0] op_b = '0;
  logic [47:0] acc_in = '0;
  logic        out_valid;
  logic [47:0] result;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  logic        ev [2];
  logic [47:0] er [2];
  logic [1:0]  eop [2];
  logic [47:0] last_res = '0;

  always #2.5 clk = ~clk;

  qsimd_mac_alu dut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
                     .op_a(op_a), .op_b(op_b), .acc_in(acc_in),
                     .out_valid(out_valid), .result(result));

  function automatic logic [23:0] lane_add(logic [1:0] op, logic [7:0] ba, logic [7:0] bb, logic [23:0] direct);
    int s, w, x, a, p;
    s = int'(ba[7:3]);
    w = int'($signed(ba[2:0]));
    x = int'($signed(bb));
    a = int'($signed(ba));
    case (op)
      2'b00: p = a * x;
      2'b10: p = s * w * x;
      default: p = int'(direct);
    endcase
    return 24'(p);
  endfunction

  function automatic logic [47:0] model(logic [1:0] op, logic [31:0] a, logic [31:0] b, logic [47:0] acc);
    logic [23:0] l0, l1;
    l0 = acc[23:0]  + lane_add(op, a[7:0],  b[7:0],  a[23:0]);
    l1 = acc[47:24] + lane_add(op, a[15:8], b[15:8], b[23:0]);
    return {l1, l0};
  endfunction

  function automatic string tag(logic [1:0] op);
    case (op)
      2'b00: return "R3/R6 byte MAC";
      2'b01: return "R4/R6 lane add";
      2'b10: return "R5/R6 scale-weight MAC";
      default: return "R7/R8 idle or reserved";
    endcase
  endfunction

  task automatic check_now();
    compared++;
    if (out_valid !== ev[1] || result !== er[1]) begin
      mismatched++;
      $display("FAIL %s (R2 timing): got v=%0b r=%h expected v=%0b r=%h",
               tag(eop[1]), out_valid, result, ev[1], er[1]);
    end
  endtask

  task automatic issue(logic v, logic [1:0] op, logic [31:0] a, logic [31:0] b, logic [47:0] acc);
    @(negedge clk);
    check_now();
    ev[1] = ev[0]; er[1] = er[0]; eop[1] = eop[0];
    in_valid = v; opcode = op; op_a = a; op_b = b; acc_in = acc;
    if (v && op != 2'b11) begin
      last_res = model(op, a, b, acc);
      ev[0] = 1'b1; er[0] = last_res; eop[0] = op;
    end else begin
      ev[0] = 1'b0; er[0] = last_res; eop[0] = 2'b11;
    end
  endtask

  initial begin
    ev[0] = 0; ev[1] = 0; er[0] = '0; er[1] = '0; eop[0] = 2'b11; eop[1] = 2'b11;
    repeat (3) @(negedge clk);
    compared++;
    if (out_valid !== 1'b0 || result !== 48'h0) begin
      mismatched++;
      $display("FAIL R1 reset: got v=%0b r=%h expected v=0 r=0", out_valid, result);
    end
    rst_n = 1'b1;
    repeat (2) issue(1'b0, 2'b00, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 48'hFFFF_FFFF_FFFF);
    for (int i = 0; i < 256; i++) begin
      for (int j = 0; j < 256; j++) begin
        logic [1:0] op;
        logic [47:0] acc;
        op = ((i + j) % 2 == 0) ? 2'b00 : 2'b10;
        acc = {24'(i * 65599 + j), 24'(j * 40503 - i)};
        if ((j % 61) == 7) issue(1'b1, 2'b11, {16'h0, 8'(i), 8'(j)}, 32'h1234, acc);
        else if ((j % 53) == 5) issue(1'b0, 2'b00, {16'h0, 8'(i), 8'(j)}, 32'h5678, acc);
        issue(1'b1, op, {16'h0, 8'(255 - j), 8'(i)}, {16'h0, 8'(i ^ j), 8'(j)}, acc);
      end
    end
    for (int k = 0; k < 512; k++) begin
      logic [31:0] a, b;
      logic [47:0] acc;
      a = {8'h0, 24'(k * 32771)};
      b = {8'h0, 24'(24'hFFFFFF - k * 97)};
      acc = (k % 4 == 0) ? 48'hFFFFFF_FFFFFF : {24'(k * 12345), 24'hFFFF00 + 24'(k)};
      issue(1'b1, 2'b01, a, b, acc);
    end
    issue(1'b1, 2'b01, 32'h0000_0001, 32'h0, 48'h000000_FFFFFF);
    issue(1'b1, 2'b00, 32'h0000_8080, 32'h0000_8080, 48'h7FFFFF_7FFFFF);
    issue(1'b1, 2'b10, 32'h0000_FCFC, 32'h0000_8080, 48'h0);
    issue(1'b1, 2'b11, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 48'h1);
    repeat (4) issue(1'b0, 2'b00, 32'h0, 32'h0, 48'h0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog expired (R2): got running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule